// File: doc/BRIEF.md
# Accelerator Cache Bypass Controller

This block sits in a shared last-level cache controller. For each fill request from an accelerator it decides whether the line should be allocated or should bypass the cache. The decision combines two inputs. The first is a coarse reuse annotation for the line, held in a small direct-mapped table without tags. The second is a progress state that shows whether the accelerator is ahead of, on, or behind the access rate it needs to meet its deadline.

Time is split into epochs of a fixed number of cycles. A monitor counts the accesses the accelerator completes in each epoch. At the end of each epoch it compares that count with a software-set target, and also with the target plus a safety margin. The resulting state holds for the whole of the next epoch. When the accelerator is ahead, bypassing is aggressive, so cache space goes back to the processor cores. When it falls behind, only lines predicted to be both cold and remote skip the cache.

Software loads the reuse table through a separate write port. Each entry holds a 2-bit reuse-count class and a 2-bit reuse-interval class. A decision leaves the block on a registered valid/bypass pair, two cycles after its access.

Top module: `acc_bypass_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `byp_valid` and `byp_bypass` are 0 after that edge, and the progress state becomes "lagging". The state stays lagging until the first epoch completes.
- R2: An access presented with `acc_valid` high in cycle t gives exactly one decision, with `byp_valid` high in cycle t+2. No `byp_valid` pulse appears without an access. `byp_bypass` is never 1 while `byp_valid` is 0.
- R3: In the last cycle of an epoch, the count for that epoch includes an access in that same cycle. If the count is at least `target_cnt + margin_cnt`, the next epoch is "ahead". Otherwise, if it is at least `target_cnt`, the next epoch is "on schedule". Otherwise the next epoch is "lagging".
- R4: An epoch lasts `epoch_len` cycles, counted from reset release. The access count starts again from zero in every epoch, so accesses never carry over between epochs.
- R5: The table index is `acc_addr[LINE_OFF_W +: IDX_W]`. The offset bits and the address bits above the index are ignored, so two addresses with the same index share one annotation.
- R6: In the "ahead" state, any access whose reuse-count class is cold (0), light (1) or moderate (2) is bypassed, whatever its interval class. Hot (3) lines are allocated.
- R7: In the "on schedule" state, an access is bypassed only when its count class is cold or light, and its interval class is far (2) or remote (3).
- R8: In the "lagging" state, an access is bypassed only when its count class is cold (0) and its interval class is remote (3). Interval classes are encoded immediate=0, near=1, far=2, remote=3.
- R9: A table write (`tbl_we`, `tbl_idx`, with `tbl_rc` as the count class and `tbl_ri` as the interval class) takes effect at the clock edge. A lookup of the same entry in the same cycle sees the newly written classes. Writes are accepted while `rst` is high.
- R10: Each decision uses the progress state in force during the cycle in which its access was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Accelerator fill access strobe |
| acc_addr | input | ADDR_W | Byte address of the access |
| epoch_len | input | EPOCH_W | Epoch length in cycles (at least 1) |
| target_cnt | input | CNT_W | Accesses per epoch needed to meet the deadline |
| margin_cnt | input | CNT_W | Safety margin added to the target for the "ahead" state |
| tbl_we | input | 1 | Reuse table write enable |
| tbl_idx | input | IDX_W | Reuse table entry to write |
| tbl_rc | input | 2 | Reuse-count class to store |
| tbl_ri | input | 2 | Reuse-interval class to store |
| byp_valid | output | 1 | A decision is present |
| byp_bypass | output | 1 | 1 means bypass the cache, 0 means allocate |

## Verification
The assertions assume that `epoch_len`, `target_cnt` and `margin_cnt` stay constant within an epoch, with `epoch_len` at least 1. They also assume that every table entry an access can reach has been written before that access, so no unknown class reaches the decision stage. The stimulus sets the epoch configuration once, before reset is released. It loads every entry it later looks up while reset is still high. It then runs back-to-back epochs whose access counts are chosen to land below the target, exactly on the target, and exactly on the target plus margin. This steps the controller through all three progress states.

// File: rtl/acc_bypass_pkg.sv
package acc_bypass_pkg;

  // Progress state; the numeric value orders aggressiveness of bypassing.
  typedef enum logic [1:0] {
    PROG_LAG     = 2'd0,
    PROG_ONTRACK = 2'd1,
    PROG_AHEAD   = 2'd2
  } prog_e;

  // Reuse annotation held per table entry.
  typedef struct packed {
    logic [1:0] rc;  // count class: cold, light, moderate, hot
    logic [1:0] ri;  // interval class: immediate, near, far, remote
  } reuse_cls_t;

  localparam int CLS_W = $bits(reuse_cls_t);

endpackage

// File: rtl/acc_progress_mon.sv
module acc_progress_mon
  import acc_bypass_pkg::*;
#(
  parameter int EPOCH_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [EPOCH_W-1:0] epoch_len,
  input  logic [CNT_W-1:0]   target_cnt,
  input  logic [CNT_W-1:0]   margin_cnt,
  output prog_e              state
);

  logic [EPOCH_W-1:0] cyc_q;
  logic [CNT_W-1:0]   cnt_q;
  prog_e              state_q;
  logic               epoch_end;
  logic [CNT_W:0]     total;
  logic [CNT_W:0]     goal_lo;
  logic [CNT_W:0]     goal_hi;
  logic               cnt_full;

  // Wide compare so that epoch_len == 0 also ends every cycle.
  assign epoch_end = ({1'b0, cyc_q} + (EPOCH_W+1)'(1)) >= {1'b0, epoch_len};
  assign cnt_full  = &cnt_q;

  always_comb begin
    total   = {1'b0, cnt_q} + (CNT_W+1)'(acc_valid);
    goal_lo = {1'b0, target_cnt};
    goal_hi = goal_lo + {1'b0, margin_cnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q   <= '0;
      cnt_q   <= '0;
      state_q <= PROG_LAG;
    end else if (epoch_end) begin
      cyc_q <= '0;
      cnt_q <= '0;
      if (total >= goal_hi)      state_q <= PROG_AHEAD;
      else if (total >= goal_lo) state_q <= PROG_ONTRACK;
      else                       state_q <= PROG_LAG;
    end else begin
      cyc_q <= cyc_q + EPOCH_W'(1);
      if (acc_valid && !cnt_full) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign state = state_q;

  // R1: reset forces the lagging state
  a_r1_reset_lag: assert property (@(posedge clk) rst |=> state_q == PROG_LAG);

  // R4: counters restart at each epoch boundary
  a_r4_epoch_clear: assert property (@(posedge clk) disable iff (rst)
    epoch_end |=> (cnt_q == '0) && (cyc_q == '0));

  // R3: the state holds inside an epoch
  a_r3_state_hold: assert property (@(posedge clk) disable iff (rst)
    !epoch_end |=> $stable(state_q));

  // R3: counting moves by at most one per cycle inside an epoch
  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    !epoch_end && !acc_valid |=> $stable(cnt_q));

endmodule

// File: rtl/acc_reuse_table.sv
module acc_reuse_table
  import acc_bypass_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  reuse_cls_t       wr_data,
  output reuse_cls_t       rd_data
);

  localparam int DEPTH = 1 << IDX_W;

  reuse_cls_t mem [DEPTH];
  reuse_cls_t ram_q;
  reuse_cls_t fwd_q;
  logic       use_fwd_q;

  // Plain synchronous-read RAM; the collision path sits outside it.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) ram_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_fwd_q <= 1'b0;
      fwd_q     <= '0;
    end else if (rd_en) begin
      use_fwd_q <= wr_en && (wr_idx == rd_idx);
      fwd_q     <= wr_data;
    end
  end

  assign rd_data = use_fwd_q ? fwd_q : ram_q;

  // R9: a write to the entry being looked up wins
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    rd_en && wr_en && (wr_idx == rd_idx) |=> rd_data == $past(wr_data));

endmodule

// File: rtl/acc_bypass_decide.sv
module acc_bypass_decide
  import acc_bypass_pkg::*;
#(
  parameter logic [1:0] RC_THR_AHEAD   = 2'd2,
  parameter logic [1:0] RI_THR_AHEAD   = 2'd0,
  parameter logic [1:0] RC_THR_ONTRACK = 2'd1,
  parameter logic [1:0] RI_THR_ONTRACK = 2'd2,
  parameter logic [1:0] RC_THR_LAG     = 2'd0,
  parameter logic [1:0] RI_THR_LAG     = 2'd3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  prog_e      in_state,
  input  reuse_cls_t in_cls,
  output logic       out_valid,
  output logic       out_bypass
);

  localparam int NSTATE = 3;
  // Thresholds packed by state value: [LAG, ONTRACK, AHEAD] from bit 0.
  localparam logic [2*NSTATE-1:0] RC_TAB = {RC_THR_AHEAD, RC_THR_ONTRACK, RC_THR_LAG};
  localparam logic [2*NSTATE-1:0] RI_TAB = {RI_THR_AHEAD, RI_THR_ONTRACK, RI_THR_LAG};

  logic [3:0] hit;
  logic [1:0] sel;

  genvar g;
  generate
    for (g = 0; g < NSTATE; g++) begin : g_rule
      assign hit[g] = (in_cls.rc <= RC_TAB[2*g +: 2]) && (in_cls.ri >= RI_TAB[2*g +: 2]);
    end
  endgenerate
  assign hit[3] = 1'b0;
  assign sel    = in_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_bypass <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      out_bypass <= in_valid && hit[sel];
    end
  end

  // R6: classes above the ahead count threshold are allocated
  a_r6_hot_kept: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_state == PROG_AHEAD) && (in_cls.rc > RC_THR_AHEAD) |=> !out_bypass);

  // R8: while lagging, anything short of the coldest/farthest class is kept
  a_r8_lag_keep: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_state == PROG_LAG) && ((in_cls.rc > RC_THR_LAG) || (in_cls.ri < RI_THR_LAG))
    |=> !out_bypass);

  // R7: on schedule, a near-term interval is never bypassed
  a_r7_near_kept: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_state == PROG_ONTRACK) && (in_cls.ri < RI_THR_ONTRACK) |=> !out_bypass);

endmodule

// File: rtl/acc_bypass_ctrl.sv
module acc_bypass_ctrl
  import acc_bypass_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_OFF_W = 6,
  parameter int IDX_W      = 8,
  parameter int EPOCH_W    = 16,
  parameter int CNT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [EPOCH_W-1:0] epoch_len,
  input  logic [CNT_W-1:0]   target_cnt,
  input  logic [CNT_W-1:0]   margin_cnt,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [1:0]         tbl_rc,
  input  logic [1:0]         tbl_ri,
  output logic               byp_valid,
  output logic               byp_bypass
);

  localparam int HI_LSB = LINE_OFF_W + IDX_W;

  logic [IDX_W-1:0] look_idx;
  logic             addr_unused;
  prog_e            prog_state;
  prog_e            s1_state_q;
  logic             s1_valid_q;
  reuse_cls_t       wr_cls;
  reuse_cls_t       look_cls;

  assign look_idx    = acc_addr[LINE_OFF_W +: IDX_W];
  assign addr_unused = ^{acc_addr[ADDR_W-1:HI_LSB], acc_addr[LINE_OFF_W-1:0]};
  assign wr_cls      = '{rc: tbl_rc, ri: tbl_ri};

  acc_progress_mon #(
    .EPOCH_W (EPOCH_W),
    .CNT_W   (CNT_W)
  ) u_mon (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .epoch_len  (epoch_len),
    .target_cnt (target_cnt),
    .margin_cnt (margin_cnt),
    .state      (prog_state)
  );

  acc_reuse_table #(
    .IDX_W (IDX_W)
  ) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (acc_valid),
    .rd_idx  (look_idx),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_idx),
    .wr_data (wr_cls),
    .rd_data (look_cls)
  );

  // Carry the state of the access cycle alongside the table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid_q <= 1'b0;
      s1_state_q <= PROG_LAG;
    end else begin
      s1_valid_q <= acc_valid;
      s1_state_q <= prog_state;
    end
  end

  acc_bypass_decide u_dec (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (s1_valid_q),
    .in_state   (s1_state_q),
    .in_cls     (look_cls),
    .out_valid  (byp_valid),
    .out_bypass (byp_bypass)
  );

  // R2: every access yields a decision two cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> ##1 byp_valid);

  // R2: no decision without an access
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ##1 !byp_valid);

  // R2: bypass only qualifies a valid decision
  a_r2_bypass_qual: assert property (@(posedge clk) disable iff (rst)
    byp_bypass |-> byp_valid);

  // R10: the decision stage sees the state of the access cycle
  a_r10_state_align: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> s1_state_q == $past(prog_state));

endmodule

// File: tb/acc_bypass_ctrl_tb.sv
module acc_bypass_ctrl_tb;

  localparam int ADDR_W = 32;
  localparam int OFF_W  = 6;
  localparam int IDX_W  = 8;
  localparam int EPOCH_W = 16;
  localparam int CNT_W  = 16;
  localparam int EPOCH  = 16;
  localparam int TARGET = 8;
  localparam int MARGIN = 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               acc_valid = 1'b0;
  logic [ADDR_W-1:0]  acc_addr = '0;
  logic [EPOCH_W-1:0] epoch_len = EPOCH_W'(EPOCH);
  logic [CNT_W-1:0]   target_cnt = CNT_W'(TARGET);
  logic [CNT_W-1:0]   margin_cnt = CNT_W'(MARGIN);
  logic               tbl_we = 1'b0;
  logic [IDX_W-1:0]   tbl_idx = '0;
  logic [1:0]         tbl_rc = '0;
  logic [1:0]         tbl_ri = '0;
  logic               byp_valid;
  logic               byp_bypass;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk = ~clk;

  acc_bypass_ctrl #(
    .ADDR_W (ADDR_W), .LINE_OFF_W (OFF_W), .IDX_W (IDX_W),
    .EPOCH_W (EPOCH_W), .CNT_W (CNT_W)
  ) u_dut (
    .clk (clk), .rst (rst), .acc_valid (acc_valid), .acc_addr (acc_addr),
    .epoch_len (epoch_len), .target_cnt (target_cnt), .margin_cnt (margin_cnt),
    .tbl_we (tbl_we), .tbl_idx (tbl_idx), .tbl_rc (tbl_rc), .tbl_ri (tbl_ri),
    .byp_valid (byp_valid), .byp_bypass (byp_bypass)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference rules, written from the requirements (0 lag, 1 on schedule, 2 ahead).
  function automatic bit ref_rule(input int st, input logic [1:0] rc, input logic [1:0] ri);
    case (st)
      2:       return rc <= 2'd2;
      1:       return (rc <= 2'd1) && (ri >= 2'd2);
      default: return (rc == 2'd0) && (ri == 2'd3);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int hi, input int idx);
    return {18'(hi), 8'(idx), 6'h2b};
  endfunction

  // Reference model of progress and table contents.
  int         m_cyc, m_cnt, m_state;
  logic [3:0] m_tbl [256];
  bit         e1_v, e1_b, e2_v, e2_b;
  int         e1_s, e2_s;

  always @(posedge clk) begin
    logic [3:0] ent;
    int         idx;
    int         tot;
    idx = int'(acc_addr[OFF_W +: IDX_W]);
    ent = (tbl_we && (int'(tbl_idx) == idx)) ? {tbl_rc, tbl_ri} : m_tbl[idx];
    if (tbl_we) m_tbl[tbl_idx] <= {tbl_rc, tbl_ri};
    if (rst) begin
      m_cyc <= 0; m_cnt <= 0; m_state <= 0;
      e1_v <= 0; e1_b <= 0; e2_v <= 0; e2_b <= 0; e1_s <= 0; e2_s <= 0;
    end else begin
      e1_v <= acc_valid;
      e1_b <= acc_valid && ref_rule(m_state, ent[3:2], ent[1:0]);
      e1_s <= m_state;
      e2_v <= e1_v; e2_b <= e1_b; e2_s <= e1_s;
      if (m_cyc + 1 >= EPOCH) begin
        tot = m_cnt + int'(acc_valid);
        m_state <= (tot >= TARGET + MARGIN) ? 2 : (tot >= TARGET) ? 1 : 0;
        m_cyc <= 0;
        m_cnt <= 0;
      end else begin
        m_cyc <= m_cyc + 1;
        m_cnt <= m_cnt + int'(acc_valid);
      end
    end
  end

  // Every decision compared with the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && (e2_v || byp_valid)) begin
      check(byp_valid == e2_v, "R2", "decision valid", int'(byp_valid), int'(e2_v));
      if (e2_v)
        check(byp_bypass == e2_b, (e2_s == 2) ? "R6" : (e2_s == 1) ? "R7" : "R8",
              "bypass decision", int'(byp_bypass), int'(e2_b));
    end
  end

  task automatic t_reset();
    @(negedge clk);
    check(byp_valid == 1'b0, "R1", "valid in reset", int'(byp_valid), 0);
    check(byp_bypass == 1'b0, "R1", "bypass in reset", int'(byp_bypass), 0);
  endtask

  // Entry i holds count class i[3:2] and interval class i[1:0]; entry 20 is hot/immediate.
  task automatic t_load_table();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_idx = IDX_W'(i); tbl_rc = 2'(i >> 2); tbl_ri = 2'(i);
    end
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IDX_W'(20); tbl_rc = 2'd3; tbl_ri = 2'd0;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // One epoch; counts bypasses for accesses in cycles 0..13 of it.
  task automatic t_epoch(input string tag, input int start, input int n,
                         input int first, input int exp);
    int got = 0;
    for (int t = 0; t < EPOCH; t++) begin
      @(negedge clk);
      if (t >= 2 && byp_valid && byp_bypass) got++;
      acc_valid = (t >= start) && (t < start + n);
      acc_addr  = mk_addr(t, (first + t - start) & 15);
    end
    check(got == exp, tag, "bypass count", got, exp);
  endtask

  // Lagging epoch: same-cycle write, aliasing and ignored bits.
  task automatic t_table_corner();
    @(negedge clk);
    acc_valid = 1'b0;
    tbl_we = 1'b1; tbl_idx = IDX_W'(20); tbl_rc = 2'd3; tbl_ri = 2'd0;
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IDX_W'(20); tbl_rc = 2'd0; tbl_ri = 2'd3;
    acc_valid = 1'b1; acc_addr = mk_addr(0, 20);
    @(negedge clk);
    tbl_we = 1'b0;
    acc_addr = mk_addr(5, 3);
    @(negedge clk);
    check(byp_valid && byp_bypass, "R9", "same-cycle write seen", int'(byp_bypass), 1);
    acc_addr = mk_addr(7, 12);
    @(negedge clk);
    check(byp_valid && byp_bypass, "R5", "aliased address shares entry", int'(byp_bypass), 1);
    acc_valid = 1'b0;
    @(negedge clk);
    check(byp_valid && !byp_bypass, "R8", "hot line kept while lagging", int'(byp_bypass), 0);
    @(negedge clk);
    check(!byp_valid, "R2", "no decision without access", int'(byp_valid), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_load_table();
    @(posedge clk);
    rst <= 1'b0;
    t_epoch("R8 R1 lagging after reset", 0, 16, 0, 1);
    t_epoch("R6 R10 ahead after full epoch", 0, 16, 0, 12);
    t_epoch("R6 ahead partial burst", 0, 10, 0, 10);
    t_epoch("R7 R3 on schedule", 0, 16, 0, 4);
    t_epoch("R6 hot kept while ahead", 0, 7, 12, 3);
    t_epoch("R8 R3 lagging below target", 0, 8, 0, 1);
    t_epoch("R7 R4 count restarts, exactly on target", 5, 11, 0, 4);
    t_epoch("R7 on schedule late burst", 4, 12, 0, 4);
    t_epoch("R3 boundary-cycle access reaches margin", 0, 4, 8, 4);
    t_table_corner();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #4000000;
    n_checks++;
    n_err++;
    $display("FAIL R2 watchdog expired: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule